// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block sits between a word-wide memory bus and an instruction decoder. It fills a short byte FIFO with the instruction bytes that follow the current fetch pointer. To do so it issues word-wide read cycles at sequential aligned addresses whenever the bus is free and the FIFO can take a whole word. The decoder takes bytes from the head of the FIFO, one per cycle, using a pop strobe qualified by a byte-valid flag.

The execution side can ask for an operand read or write over the same bus. Such a request wins over any new prefetch, but a fetch cycle that is already on the bus always runs to completion first. A flush on a taken branch empties the FIFO at once and reloads the fetch pointer with the target. If a fetch is still on the bus at that moment, the word it returns is dropped. When the target is odd, the first word fetched supplies only its upper byte. After that, fetching continues at aligned addresses.

Bus protocol: `mem_req` is held with a stable address until `mem_ack` is seen high at a clock edge, which ends the cycle. Operand requests are levels: the requester holds `op_req` until `op_done` pulses, and a new operand is not accepted in the cycle of that pulse.

Top module: `prefetch_queue_ctrl`

## Requirements
- R1: While reset is asserted (synchronous, active low), `q_valid` and `mem_req` are both 0.
- R2: Popped bytes arrive strictly in address order, starting at the reset address (0) or at the last flush target, with no byte skipped or repeated.
- R3: Every prefetch bus cycle uses a word-aligned address (the low log2(DW/8) address bits are 0); byte lane k of `mem_rdata` (bits 8k+7..8k) holds the byte at that address plus k.
- R4: The FIFO holds at most DEPTH bytes, and a prefetch starts only when at least DW/8 slots are free; with DEPTH 6 and no further fill, exactly six pops return valid bytes.
- R5: An operand request present in a cycle where a prefetch could also start wins the bus.
- R6: A fetch already on the bus when an operand request arrives keeps its address until acknowledged and delivers its bytes before the operand cycle starts.
- R7: A flush clears the FIFO: `q_valid` is 0 in the cycle after the flush.
- R8: With the FIFO full and no operand request, `mem_req` stays 0.
- R9: After a flush to an odd target, the first byte delivered is the byte at that odd address.
- R10: Data returned by a fetch that was on the bus when a flush arrived never reaches the FIFO.
- R11: A pop while `q_valid` is 0 has no effect; the next byte delivered is still the first byte due.
- R12: An operand cycle drives `op_addr`, `op_we` and `op_wdata` onto the bus; `op_done` pulses for one cycle after the acknowledge, with `op_rdata` holding the word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Branch taken: empty the FIFO and reload the fetch pointer |
| flush_addr | input | AW | New fetch target, used when flush is high |
| pop | input | 1 | Decoder takes the head byte |
| q_byte | output | 8 | Head byte of the FIFO |
| q_valid | output | 1 | Head byte is valid |
| op_req | input | 1 | Operand bus request (level) |
| op_addr | input | AW | Operand address |
| op_we | input | 1 | Operand write when 1, read when 0 |
| op_wdata | input | DW | Operand write data |
| op_done | output | 1 | One-cycle operand completion pulse |
| op_rdata | output | DW | Operand read data, valid with op_done |
| mem_req | output | 1 | Bus cycle active |
| mem_addr | output | AW | Bus address |
| mem_we | output | 1 | Bus write strobe |
| mem_wdata | output | DW | Bus write data |
| mem_ack | input | 1 | Bus acknowledge, ends the cycle |
| mem_rdata | input | DW | Bus read data, valid with mem_ack |

## Verification
The bench builds the block with DEPTH 6, a 16-bit data word (two byte lanes) and a 16-bit address, so a real six-slot ring that wraps at a non-power-of-two boundary, a full-queue stall and an odd flush target are all reached within a few dozen cycles. The latency of the memory model is changed between phases. A one-cycle latency streams bytes past the wrap many times. A six- or eight-cycle latency keeps a fetch on the bus long enough for a flush or an operand request to land in the middle of it, and lets the queue drain to empty for the capacity and empty-pop checks.

// File: rtl/pfq_pkg.sv
// Shared types for the prefetch queue controller.
package pfq_pkg;

    // Bus owner state: idle, instruction prefetch or operand access.
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_FETCH = 2'd1,
        BUS_OPER  = 2'd2
    } bus_state_e;

endpackage

// File: rtl/pfq_byte_fifo.sv
// Byte ring buffer of DEPTH slots (any DEPTH, wraps without power-of-two).
// Accepts 0..BYTES bytes per cycle from a fetch, lane 0 first, and gives one
// byte per pop. Clear empties it and wins over push and pop in the same cycle.
// Assumes the writer never pushes more bytes than there are free slots.
module pfq_byte_fifo #(
    parameter int DEPTH = 6,
    parameter int BYTES = 2,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int PCW   = $clog2(BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [PCW-1:0]     push_cnt,
    input  logic [BYTES*8-1:0] push_data,
    input  logic               pop,
    output logic [7:0]         head,
    output logic [CW-1:0]      occ
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    store [DEPTH];
    logic [IW-1:0] rd_idx;
    logic [IW-1:0] wr_idx;
    logic          pop_eff;

    // Ring index plus an offset, wrapped at DEPTH.
    function automatic logic [IW-1:0] ring_add(input logic [IW-1:0] base, input int inc);
        int s;
        s = int'(base) + inc;
        if (s >= DEPTH) s = s - DEPTH;
        return IW'(s);
    endfunction

    // A pop only counts when a byte is present and no clear is under way.
    assign pop_eff = pop && (occ != '0) && !clear;
    assign head    = store[rd_idx];

    // Byte storage: write the pushed lanes into consecutive slots.
    always_ff @(posedge clk) begin
        if (!clear) begin
            for (int i = 0; i < BYTES; i++) begin
                if (i < int'(push_cnt)) begin
                    store[ring_add(wr_idx, i)] <= push_data[i*8 +: 8];
                end
            end
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_idx <= '0;
            wr_idx <= '0;
            occ    <= '0;
        end else begin
            wr_idx <= ring_add(wr_idx, int'(push_cnt));
            if (pop_eff) rd_idx <= ring_add(rd_idx, 1);
            occ <= occ + CW'(push_cnt) - CW'(pop_eff);
        end
    end

endmodule

// File: rtl/pfq_fetch_ptr.sv
// Next-instruction-byte pointer. Gives the aligned word address to fetch,
// the lane of the first wanted byte and how many bytes that fetch yields.
// Reload on flush wins over the advance that follows an accepted fetch.
module pfq_fetch_ptr #(
    parameter int          AW         = 20,
    parameter int          BYTES      = 2,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    parameter int          OFFW       = (BYTES > 1) ? $clog2(BYTES) : 1,
    parameter int          PCW        = $clog2(BYTES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   load_addr,
    input  logic            advance,
    output logic [AW-1:0]   word_addr,
    output logic [OFFW-1:0] lane_off,
    output logic [PCW-1:0]  byte_cnt
);
    logic [AW-1:0] ptr;

    assign lane_off  = ptr[OFFW-1:0];
    assign word_addr = {ptr[AW-1:OFFW], {OFFW{1'b0}}};
    assign byte_cnt  = PCW'(BYTES) - PCW'(lane_off);

    // Pointer update: reset, reload on branch, or step past the bytes kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= RESET_ADDR;
        end else if (load) begin
            ptr <= load_addr;
        end else if (advance) begin
            ptr <= ptr + AW'(byte_cnt);
        end
    end

endmodule

// File: rtl/pfq_bus_arb.sv
// Bus sequencer. From idle it grants an operand request first, otherwise a
// prefetch when the FIFO has room and no flush is present. A started cycle
// holds its address until mem_ack; a fetch is never abandoned. A flush during
// a fetch marks the returning word stale so it is dropped.
module pfq_bus_arb
    import pfq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          room_ok,
    input  logic [AW-1:0] fetch_addr,
    input  logic          op_req,
    input  logic [AW-1:0] op_addr,
    input  logic          op_we,
    input  logic [DW-1:0] op_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          fetch_cyc,
    output logic          fetch_keep,
    output logic          op_done,
    output logic [DW-1:0] op_rdata
);
    bus_state_e    state;
    logic          stale;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [DW-1:0] wdata_q;
    logic          take_op;
    logic          take_fetch;

    assign take_op    = (state == BUS_IDLE) && op_req && !op_done;
    assign take_fetch = (state == BUS_IDLE) && !take_op && room_ok && !flush;

    assign mem_req    = (state != BUS_IDLE);
    assign mem_addr   = addr_q;
    assign mem_we     = we_q;
    assign mem_wdata  = wdata_q;
    assign fetch_cyc  = (state == BUS_FETCH);
    assign fetch_keep = (state == BUS_FETCH) && mem_ack && !stale && !flush;

    // State machine and latched cycle attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BUS_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            unique case (state)
                BUS_IDLE: begin
                    if (take_op) begin
                        state   <= BUS_OPER;
                        addr_q  <= op_addr;
                        we_q    <= op_we;
                        wdata_q <= op_wdata;
                    end else if (take_fetch) begin
                        state   <= BUS_FETCH;
                        addr_q  <= fetch_addr;
                        we_q    <= 1'b0;
                        wdata_q <= '0;
                    end
                end
                BUS_FETCH: if (mem_ack) state <= BUS_IDLE;
                BUS_OPER:  if (mem_ack) state <= BUS_IDLE;
                default:   state <= BUS_IDLE;
            endcase
        end
    end

    // Stale marker for a fetch overtaken by a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale <= 1'b0;
        end else if (state != BUS_FETCH || mem_ack) begin
            stale <= 1'b0;
        end else if (flush) begin
            stale <= 1'b1;
        end
    end

    // Operand completion pulse and captured read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_done  <= 1'b0;
            op_rdata <= '0;
        end else begin
            op_done <= (state == BUS_OPER) && mem_ack;
            if ((state == BUS_OPER) && mem_ack) op_rdata <= mem_rdata;
        end
    end

endmodule

// File: rtl/prefetch_queue_ctrl.sv
// Instruction prefetch queue controller, top level. Ties together the fetch
// pointer, the bus sequencer and the byte FIFO. Assumes DW is a multiple of 8
// with a power-of-two lane count, and DEPTH >= DW/8.
module prefetch_queue_ctrl #(
    parameter int            AW         = 20,
    parameter int            DW         = 16,
    parameter int            DEPTH      = 6,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          pop,
    output logic [7:0]    q_byte,
    output logic          q_valid,
    input  logic          op_req,
    input  logic [AW-1:0] op_addr,
    input  logic          op_we,
    input  logic [DW-1:0] op_wdata,
    output logic          op_done,
    output logic [DW-1:0] op_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam int BYTES = DW / 8;
    localparam int OFFW  = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int PCW   = $clog2(BYTES + 1);
    localparam int CW    = $clog2(DEPTH + 1);

    logic [AW-1:0]   word_addr;
    logic [OFFW-1:0] lane_off;
    logic [PCW-1:0]  byte_cnt;
    logic [CW-1:0]   occ;
    logic            room_ok;
    logic            fetch_cyc;
    logic            fetch_keep;
    logic [PCW-1:0]  push_cnt;
    logic [DW-1:0]   push_data;

    assign room_ok   = (occ <= CW'(DEPTH - BYTES));
    assign push_cnt  = fetch_keep ? byte_cnt : '0;
    assign push_data = mem_rdata >> {lane_off, 3'b000};
    assign q_valid   = (occ != '0);

    pfq_fetch_ptr #(
        .AW         (AW),
        .BYTES      (BYTES),
        .RESET_ADDR (RESET_ADDR)
    ) ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (flush),
        .load_addr (flush_addr),
        .advance   (fetch_keep),
        .word_addr (word_addr),
        .lane_off  (lane_off),
        .byte_cnt  (byte_cnt)
    );

    pfq_bus_arb #(
        .AW (AW),
        .DW (DW)
    ) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .room_ok    (room_ok),
        .fetch_addr (word_addr),
        .op_req     (op_req),
        .op_addr    (op_addr),
        .op_we      (op_we),
        .op_wdata   (op_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .fetch_cyc  (fetch_cyc),
        .fetch_keep (fetch_keep),
        .op_done    (op_done),
        .op_rdata   (op_rdata)
    );

    pfq_byte_fifo #(
        .DEPTH (DEPTH),
        .BYTES (BYTES)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push_cnt  (push_cnt),
        .push_data (push_data),
        .pop       (pop),
        .head      (q_byte),
        .occ       (occ)
    );

endmodule

// File: rtl/pfq_checker.sv
// Property checker for prefetch_queue_ctrl, attached by bind below.
// Observes ports plus the FIFO occupancy and the fetch-cycle flag.
module pfq_checker #(
    parameter int AW    = 20,
    parameter int DEPTH = 6,
    parameter int OFFW  = 1,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          q_valid,
    input logic          op_req,
    input logic          op_done,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          fetch_cyc,
    input logic [CW-1:0] occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R4

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cyc |-> (mem_addr[OFFW-1:0] == '0)); // R3

    AST_CYCLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !q_valid); // R7

    AST_IDLE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && occ == CW'(DEPTH) && !op_req && !flush) |=> !mem_req); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done); // R12

endmodule

bind prefetch_queue_ctrl pfq_checker #(
    .AW    (AW),
    .DEPTH (DEPTH),
    .OFFW  (OFFW),
    .CW    (CW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .q_valid   (q_valid),
    .op_req    (op_req),
    .op_done   (op_done),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .fetch_cyc (fetch_cyc),
    .occ       (occ)
);

// File: tb/prefetch_queue_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: flush/reset pushes the expected byte stream into a queue,
// the per-cycle monitor pops and compares every byte the decoder takes.
module prefetch_queue_ctrl_tb_top;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int DEPTH = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [AW-1:0] flush_addr = '0;
    logic          pop = 1'b0;
    logic [7:0]    q_byte;
    logic          q_valid;
    logic          op_req = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic          op_we = 1'b0;
    logic [DW-1:0] op_wdata = '0;
    logic          op_done;
    logic [DW-1:0] op_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int   checks = 0;
    int   fails  = 0;
    int   lat    = 2;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    prefetch_queue_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (.*);

    // Memory image: byte value as a function of its address.
    function automatic logic [7:0] mb(input logic [AW-1:0] a);
        return 8'(a[7:0] * 8'd13 + a[15:8] + 8'h21);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver side: expected stream from a start address.
    task automatic load_expect(input logic [AW-1:0] start);
        exp_q.delete();
        for (int k = 0; k < 200; k++) exp_q.push_back(mb(AW'(start + AW'(k))));
    endtask

    // Memory model: acknowledges after lat cycles with the aligned word.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                cnt++;
                if (cnt >= lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = {mb(AW'(mem_addr + 1)), mb(mem_addr)};
                    cnt = 0;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // One cycle: set pop/flush for the coming edge and monitor outputs.
    task automatic tick(input logic p, input logic fl, input logic [AW-1:0] tgt);
        @(negedge clk);
        pop = p;
        flush = fl;
        flush_addr = tgt;
        if (fl) begin
            load_expect(tgt);
        end else if (p && q_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R2", q_byte, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(q_byte == e, "R2", q_byte, e);
            end
        end
        if (mem_req && !mem_we) check(mem_addr[0] == 1'b0, "R3", mem_addr, {mem_addr[AW-1:1], 1'b0});
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!q_valid && n < 60) begin
            tick(1'b0, 1'b0, '0);
            n++;
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!op_done && n < 60) begin
            tick(1'b0, 1'b0, '0);
            n++;
        end
        check(op_done, "R12", op_done, 1);
        op_req = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int nv;
        logic [AW-1:0] fa;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!q_valid, "R1", q_valid, 0);
        check(!mem_req, "R1", mem_req, 0);
        load_expect('0);
        rst_n = 1'b1;

        // R8: queue fills and bus goes idle
        repeat (20) tick(1'b0, 1'b0, '0);
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 1'b0, '0);
            check(!mem_req, "R8", mem_req, 0);
        end

        // R4: exactly DEPTH bytes available with a slow refill
        lat = 8;
        nv = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_valid) nv++;
            tick(1'b1, 1'b0, '0);
        end
        tick(1'b0, 1'b0, '0);
        check(nv == DEPTH, "R4", nv, DEPTH);
        check(!q_valid, "R4", q_valid, 0);

        // R2: streaming with fast memory
        lat = 1;
        for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, '0);

        // R7 and R9: flush to odd target
        tick(1'b0, 1'b1, 16'h0103);
        tick(1'b0, 1'b0, '0);
        check(!q_valid, "R7", q_valid, 0);
        wait_valid();
        check(q_byte == mb(16'h0103), "R9", q_byte, mb(16'h0103));
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, '0);

        // R10: flush while a fetch is on the bus
        lat = 6;
        tick(1'b0, 1'b1, 16'h0200);
        tick(1'b0, 1'b0, '0);
        tick(1'b0, 1'b0, '0);
        check(mem_req, "R10", mem_req, 1);
        tick(1'b0, 1'b1, 16'h0300);
        wait_valid();
        check(q_byte == mb(16'h0300), "R10", q_byte, mb(16'h0300));
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, '0);

        // R11: pops while empty are ignored
        tick(1'b0, 1'b1, 16'h0400);
        for (int i = 0; i < 3; i++) begin
            tick(1'b1, 1'b0, '0);
            check(!q_valid, "R11", q_valid, 0);
        end
        tick(1'b0, 1'b0, '0);
        wait_valid();
        check(q_byte == mb(16'h0400), "R11", q_byte, mb(16'h0400));

        // R5: operand beats a prefetch that has room
        repeat (40) tick(1'b0, 1'b0, '0);
        check(!mem_req, "R8", mem_req, 0);
        tick(1'b1, 1'b0, '0);
        tick(1'b1, 1'b0, '0);
        tick(1'b0, 1'b0, '0);
        op_req = 1'b1; op_addr = 16'h00A0; op_we = 1'b0;
        tick(1'b0, 1'b0, '0);
        check(mem_req && mem_addr == 16'h00A0, "R5", mem_addr, 16'h00A0);
        check(!mem_we, "R5", mem_we, 0);
        wait_done();
        check(op_rdata == {mb(16'h00A1), mb(16'h00A0)}, "R12", op_rdata, {mb(16'h00A1), mb(16'h00A0)});

        // R6: fetch in flight completes before the operand write
        tick(1'b0, 1'b1, 16'h0600);
        fa = '1;
        for (int i = 0; i < 40 && fa != 16'h0600; i++) begin
            tick(1'b0, 1'b0, '0);
            if (mem_req && !mem_we && mem_addr == 16'h0600) fa = mem_addr;
        end
        op_req = 1'b1; op_addr = 16'h00C0; op_we = 1'b1; op_wdata = 16'hBEEF;
        tick(1'b0, 1'b0, '0);
        check(mem_req && mem_addr == 16'h0600, "R6", mem_addr, 16'h0600);
        for (int i = 0; i < 40 && !(mem_req && mem_addr == 16'h00C0); i++) tick(1'b0, 1'b0, '0);
        check(q_valid, "R6", q_valid, 1);
        check(mem_we && mem_wdata == 16'hBEEF, "R12", mem_wdata, 16'hBEEF);
        wait_done();
        op_we = 1'b0;

        // R2: drain and stream once more
        lat = 1;
        for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, '0);
        tick(1'b0, 1'b0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule